// File: doc/BRIEF.md
# Scaled and Memory-Indirect Effective Address Generator

This block forms 32-bit effective addresses for a full indexed addressing scheme. Each request carries a base register value, an index register value with a width selector and a power-of-two scale, a base displacement of selectable size, an outer displacement, four independent suppress flags and a mode code. In plain scaled indexing the sum of the base, the scaled index and the base displacement comes back one cycle after the request is accepted.

Two further modes use a pointer held in memory. The block computes a first-phase address and fetches a longword there through a simple request/acknowledge read port. It then adds a second-phase addend to that longword. In pre-indexed mode the scaled index is part of the fetch address. In post-indexed mode the scaled index is added after the fetch, together with the outer displacement.

The block takes one request at a time. The result is marked by a one-cycle valid strobe, after which the block is ready for the next request.

Top module: `ea_gen`

## Requirements
- R1: When a request is accepted (`in_valid` and `in_ready` high at a clock edge) with mode code 0, `ea_valid` is high for exactly the next cycle, and `ea` then equals bd + base + scaled index, modulo 2^32. `mem_req` stays low throughout.
- R2: Scale code 0, 1, 2 or 3 multiplies the selected index by 1, 2, 4 or 8 respectively, by a left shift that discards the bits shifted out of the 32-bit word.
- R3: Base displacement size code 0 sign-extends bits 7:0 of `bdisp`. Code 1 sign-extends bits 15:0. Codes 2 and 3 use all 32 bits.
- R4: With `idx_long` low, the index is bits 15:0 of `idx_reg` sign-extended to 32 bits. With `idx_long` high, the index is the full register.
- R5: Each bit of `sup` forces one term to zero: bit 0 the base register, bit 1 the index, bit 2 the base displacement, bit 3 the outer displacement.
- R6: Mode code 1 (pre-indexed) reads memory at bd + base + scaled index. The result is the returned longword plus the outer displacement.
- R7: Mode code 2 (post-indexed) reads memory at bd + base. The result is the returned longword plus the scaled index plus the outer displacement.
- R8: With `odisp_long` low, the outer displacement is bits 15:0 of `odisp` sign-extended. With it high, all 32 bits are used. In modes 0 and 3 the outer displacement has no effect on `ea`.
- R9: In an indirect mode, `mem_req` rises the cycle after acceptance and stays high, with `mem_addr` unchanged, until `mem_ack` is seen. `ea_valid` is high in the cycle after the acknowledge. `in_ready` is low while a request is in progress. `mem_ack` has no effect while no fetch is pending.
- R10: Mode code 3 behaves exactly as mode code 0.
- R11: After reset, `in_ready` is high, and `mem_req` and `ea_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept a request |
| mode | input | 2 | 0 plain, 1 pre-indexed, 2 post-indexed, 3 plain |
| base_reg | input | 32 | Base register value |
| idx_reg | input | 32 | Index register value |
| idx_long | input | 1 | Use the full index register instead of its sign-extended low half |
| scale | input | 2 | Index shift amount, 0 to 3 |
| bdisp | input | 32 | Base displacement, raw |
| bdisp_size | input | 2 | 0 byte, 1 half, 2 or 3 full width |
| odisp | input | 32 | Outer displacement, raw |
| odisp_long | input | 1 | Use the full outer displacement instead of its sign-extended low half |
| sup | input | 4 | Suppress flags: base, index, base disp, outer disp (bits 0 to 3) |
| mem_req | output | 1 | Pointer fetch request |
| mem_addr | output | 32 | Pointer fetch address |
| mem_ack | input | 1 | Fetch complete, `mem_rdata` valid |
| mem_rdata | input | 32 | Fetched pointer longword |
| ea_valid | output | 1 | One-cycle strobe marking `ea` |
| ea | output | 32 | Effective address result |

## Verification
The properties assume that the memory side raises `mem_ack` only as a reply to an outstanding `mem_req`. They also assume that `mem_rdata` is meaningful only in the cycle the acknowledge is sampled. The bench follows both rules: it drives the acknowledge for exactly one cycle, after a wait of zero to three cycles, and only while a fetch is pending.

The bench also sends a single stray acknowledge while the block is idle, and checks at the ports that it changes nothing. Each request keeps `in_valid` high for a single accepted cycle. The bench sweeps every combination of mode, scale, displacement sizes, index width and suppress flags, with operand values that include sign-bit and wrap-around cases.

// File: rtl/ea_pkg.sv
// Package: shared encodings for the effective address generator.
// Assumes a 2-bit mode code; code 3 is an alias of plain indexing.
package ea_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_PRE   = 2'd1,
        MODE_POST  = 2'd2,
        MODE_ALIAS = 2'd3
    } ea_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } ea_state_e;

    // term slots, also the bit positions of the suppress vector
    localparam int T_BASE = 0;
    localparam int T_IDX  = 1;
    localparam int T_BD   = 2;
    localparam int T_OD   = 3;
    localparam int N_TERM = 4;
endpackage

// File: rtl/ea_term_prep.sv
// Module: ea_term_prep
// Turns raw operands into four AW-bit addends: sign extension of the
// short forms, index scaling by shift, then per-term suppression.
// Assumes AW >= 16. Purely combinational.
module ea_term_prep
    import ea_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SHW = 2
) (
    input  logic [AW-1:0]  base_i,
    input  logic [AW-1:0]  idx_i,
    input  logic [AW-1:0]  bdisp_i,
    input  logic [AW-1:0]  odisp_i,
    input  logic           idx_long_i,
    input  logic [SHW-1:0] scale_i,
    input  logic [1:0]     bd_size_i,
    input  logic           od_long_i,
    input  logic [N_TERM-1:0] sup_i,
    output logic [N_TERM-1:0][AW-1:0] term_o
);
    localparam int XH = AW - 16;
    localparam int XB = AW - 8;

    logic [N_TERM-1:0][AW-1:0] raw;
    logic [AW-1:0] idx_sel;

    // Pick and scale the index, size the displacements.
    always_comb begin
        idx_sel = idx_long_i ? idx_i : {{XH{idx_i[15]}}, idx_i[15:0]};
        raw[T_BASE] = base_i;
        raw[T_IDX]  = idx_sel << scale_i;
        case (bd_size_i)
            2'd0:    raw[T_BD] = {{XB{bdisp_i[7]}}, bdisp_i[7:0]};
            2'd1:    raw[T_BD] = {{XH{bdisp_i[15]}}, bdisp_i[15:0]};
            default: raw[T_BD] = bdisp_i;
        endcase
        raw[T_OD] = od_long_i ? odisp_i : {{XH{odisp_i[15]}}, odisp_i[15:0]};
    end

    // Zero every term whose suppress flag is set.
    for (genvar g = 0; g < N_TERM; g++) begin : g_sup
        assign term_o[g] = sup_i[g] ? '0 : raw[g];
    end
endmodule

// File: rtl/ea_sum_stage.sv
// Module: ea_sum_stage
// Splits the addends into the first-phase sum (fetch address, or the
// final result in plain mode) and the addend applied after the fetch.
// Additions wrap modulo 2^AW. Purely combinational.
module ea_sum_stage
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]                  mode_i,
    input  logic [N_TERM-1:0][AW-1:0]   term_i,
    output logic [AW-1:0]               phase1_o,
    output logic [AW-1:0]               phase2_o,
    output logic                        indirect_o
);
    logic post;

    // Route the index to the phase picked by the mode.
    always_comb begin
        post       = (ea_mode_e'(mode_i) == MODE_POST);
        indirect_o = post || (ea_mode_e'(mode_i) == MODE_PRE);
        phase1_o   = term_i[T_BD] + term_i[T_BASE] + (post ? '0 : term_i[T_IDX]);
        phase2_o   = term_i[T_OD] + (post ? term_i[T_IDX] : '0);
    end
endmodule

// File: rtl/ea_seq_ctrl.sv
// Module: ea_seq_ctrl
// Sequencer: accepts one request when idle, either finishes at once
// (plain) or holds a fetch request until acknowledged, then presents
// the result for one cycle. Assumes mem_ack only answers mem_req.
module ea_seq_ctrl
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid_i,
    input  logic          indirect_i,
    input  logic [AW-1:0] phase1_i,
    input  logic [AW-1:0] phase2_i,
    input  logic          mem_ack_i,
    input  logic [AW-1:0] mem_rdata_i,
    output logic          in_ready_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          ea_valid_o,
    output logic [AW-1:0] ea_o
);
    ea_state_e     state;
    logic [AW-1:0] addr_r;
    logic [AW-1:0] add_r;
    logic [AW-1:0] ea_r;
    logic          accept;

    assign accept = in_valid_i && (state == ST_IDLE);

    // State transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (accept) state <= indirect_i ? ST_FETCH : ST_DONE;
                ST_FETCH: if (mem_ack_i) state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Capture intermediate sums and the final result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_r <= '0;
            add_r  <= '0;
            ea_r   <= '0;
        end else if (accept) begin
            addr_r <= phase1_i;
            add_r  <= phase2_i;
            ea_r   <= phase1_i;
        end else if (state == ST_FETCH && mem_ack_i) begin
            ea_r <= mem_rdata_i + add_r;
        end
    end

    assign in_ready_o = (state == ST_IDLE);
    assign mem_req_o  = (state == ST_FETCH);
    assign mem_addr_o = addr_r;
    assign ea_valid_o = (state == ST_DONE);
    assign ea_o       = ea_r;
endmodule

// File: rtl/ea_gen.sv
// Module: ea_gen (top)
// Effective address generator for scaled indexing and the two
// memory-indirect forms. Wires operand preparation, the phase adder
// and the sequencer. Assumes a single outstanding request.
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base_reg,
    input  logic [AW-1:0] idx_reg,
    input  logic          idx_long,
    input  logic [1:0]    scale,
    input  logic [AW-1:0] bdisp,
    input  logic [1:0]    bdisp_size,
    input  logic [AW-1:0] odisp,
    input  logic          odisp_long,
    input  logic [3:0]    sup,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          ea_valid,
    output logic [AW-1:0] ea
);
    logic [N_TERM-1:0][AW-1:0] terms;
    logic [AW-1:0] phase1;
    logic [AW-1:0] phase2;
    logic          indirect;

    ea_term_prep #(.AW(AW), .SHW(2)) u_prep (
        .base_i     (base_reg),
        .idx_i      (idx_reg),
        .bdisp_i    (bdisp),
        .odisp_i    (odisp),
        .idx_long_i (idx_long),
        .scale_i    (scale),
        .bd_size_i  (bdisp_size),
        .od_long_i  (odisp_long),
        .sup_i      (sup),
        .term_o     (terms)
    );

    ea_sum_stage #(.AW(AW)) u_sum (
        .mode_i     (mode),
        .term_i     (terms),
        .phase1_o   (phase1),
        .phase2_o   (phase2),
        .indirect_o (indirect)
    );

    ea_seq_ctrl #(.AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .indirect_i  (indirect),
        .phase1_i    (phase1),
        .phase2_i    (phase2),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata),
        .in_ready_o  (in_ready),
        .mem_req_o   (mem_req),
        .mem_addr_o  (mem_addr),
        .ea_valid_o  (ea_valid),
        .ea_o        (ea)
    );
endmodule

// File: rtl/ea_gen_chk.sv
// Module: ea_gen_chk
// Port-level protocol properties of ea_gen, bound into every instance.
module ea_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [1:0]    mode,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          ea_valid
);
    p_plain_no_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (mode == 2'd0)) |=> (ea_valid && !mem_req));

    p_alias_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (mode == 2'd3)) |=> (ea_valid && !mem_req));

    p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> !ea_valid);

    p_pre_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (mode == 2'd1)) |=> (mem_req && !ea_valid));

    p_post_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (mode == 2'd2)) |=> (mem_req && !ea_valid));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_valid_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (ea_valid && !mem_req));

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || ea_valid) |-> !in_ready);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .mode     (mode),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .ea_valid (ea_valid)
);

// File: tb/ea_gen_tb.sv
// Bench: sweeps every control combination with pseudo-random and
// boundary operand values; expected values computed arithmetically.
module ea_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  mode = '0;
    logic [31:0] base_reg = '0, idx_reg = '0, bdisp = '0, odisp = '0;
    logic        idx_long = 1'b0, odisp_long = 1'b0;
    logic [1:0]  scale = '0, bdisp_size = '0;
    logic [3:0]  sup = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ea_valid;
    logic [31:0] ea;

    int n_cmp = 0;
    int n_err = 0;
    logic [31:0] lfsr = 32'h1234_5678;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .base_reg(base_reg), .idx_reg(idx_reg), .idx_long(idx_long),
        .scale(scale), .bdisp(bdisp), .bdisp_size(bdisp_size), .odisp(odisp),
        .odisp_long(odisp_long), .sup(sup), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ea_valid(ea_valid), .ea(ea)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        return lfsr;
    endfunction

    function automatic logic [31:0] sext(input logic [31:0] v, input int bits);
        logic signed [31:0] s;
        if (bits == 8)       s = 32'(signed'(v[7:0]));
        else if (bits == 16) s = 32'(signed'(v[15:0]));
        else                 s = v;
        return s;
    endfunction

    // One request: drive, then follow the fetch and result protocol.
    task automatic run_one(input int k);
        logic [31:0] tb, ti, tbd, tod, rd, e_addr, e_ea;
        int delay;
        base_reg = (k % 7 == 0) ? 32'hFFFF_FFF0 : next_rand();
        idx_reg  = (k % 5 == 0) ? 32'h8000_8001 : next_rand();
        bdisp    = (k % 3 == 0) ? 32'h0000_FF80 : next_rand();
        odisp    = (k % 11 == 0) ? 32'h7FFF_8000 : next_rand();
        rd       = (k % 13 == 0) ? 32'hFFFF_FFFF : next_rand();
        delay    = k % 4;
        // R2 R4 R3 R8 R5: independent term model
        tb  = sup[0] ? 32'd0 : base_reg;
        ti  = sup[1] ? 32'd0 : (idx_long ? idx_reg : sext(idx_reg, 16)) * (32'd1 << scale);
        tbd = sup[2] ? 32'd0 : (bdisp_size == 2'd0 ? sext(bdisp, 8) :
                                bdisp_size == 2'd1 ? sext(bdisp, 16) : bdisp);
        tod = sup[3] ? 32'd0 : (odisp_long ? odisp : sext(odisp, 16));
        in_valid = 1'b1;
        chk("R9 ready before request", {31'd0, in_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (mode == 2'd0 || mode == 2'd3) begin
            e_ea = tbd + tb + ti;
            chk("R1/R10 plain valid", {31'd0, ea_valid}, 32'd1);
            chk("R1 plain no fetch", {31'd0, mem_req}, 32'd0);
            chk("R1 R2 R3 R4 R5 R8 R10 plain ea", ea, e_ea);
        end else begin
            e_addr = (mode == 2'd1) ? tbd + tb + ti : tbd + tb;
            e_ea   = (mode == 2'd1) ? rd + tod : rd + ti + tod;
            chk("R9 fetch request", {31'd0, mem_req}, 32'd1);
            chk(mode == 2'd1 ? "R6 pre fetch addr" : "R7 post fetch addr", mem_addr, e_addr);
            for (int d = 0; d < delay; d++) begin
                @(posedge clk);
                @(negedge clk);
                chk("R9 request held", {31'd0, mem_req}, 32'd1);
                chk("R9 address held", mem_addr, e_addr);
                chk("R9 busy not ready", {31'd0, in_ready}, 32'd0);
                chk("R9 no early valid", {31'd0, ea_valid}, 32'd0);
            end
            mem_ack = 1'b1;
            mem_rdata = rd;
            @(posedge clk);
            @(negedge clk);
            mem_ack = 1'b0;
            mem_rdata = next_rand();
            chk("R9 valid after ack", {31'd0, ea_valid}, 32'd1);
            chk("R9 request dropped", {31'd0, mem_req}, 32'd0);
            chk(mode == 2'd1 ? "R6 R8 pre ea" : "R7 R8 post ea", ea, e_ea);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R1 valid one cycle", {31'd0, ea_valid}, 32'd0);
    endtask

    initial begin
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset ready", {31'd0, in_ready}, 32'd1);
        chk("R11 reset req", {31'd0, mem_req}, 32'd0);
        chk("R11 reset valid", {31'd0, ea_valid}, 32'd0);
        // R9: stray acknowledge while idle does nothing
        mem_ack = 1'b1;
        mem_rdata = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        mem_ack = 1'b0;
        chk("R9 stray ack no valid", {31'd0, ea_valid}, 32'd0);
        chk("R9 stray ack still ready", {31'd0, in_ready}, 32'd1);
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 4; s++)
                for (int b = 0; b < 4; b++)
                    for (int il = 0; il < 2; il++)
                        for (int ol = 0; ol < 2; ol++)
                            for (int sp = 0; sp < 16; sp++) begin
                                mode = 2'(m); scale = 2'(s); bdisp_size = 2'(b);
                                idx_long = il[0]; odisp_long = ol[0]; sup = 4'(sp);
                                run_one(k);
                                k++;
                            end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_err++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule